// File: doc/BRIEF.md
# Programmable Power-of-Two Clock Prescaler

This block takes a master clock and produces a slower clock whose period is the master period multiplied by two raised to a 4-bit exponent. The result is a division ratio between 1 and 256. A free-running binary counter advances on every master edge. The output is a registered copy of one counter bit, chosen by the exponent, so every ratio of 2 or more has a 50% duty cycle. An exponent of zero gates the master clock straight through to the output.

Two inputs can take the output out of service: an enable, and a power-down. When either one makes the block inactive, the counter is held at zero and the data output is held low. A mode bit then decides what the pad does. It either keeps its driver enabled and holds the line low, or it drops the driver enable so the line floats. The block presents a data output and a driver-enable output, so a tri-state pad cell can be placed next to it.

The effective exponent is a held copy of the input. It is refreshed only while the block is inactive or in reset, or when the counter wraps. A ratio change therefore never cuts a high or low phase short.

Top module: `pow2_prescaler`

## Requirements
- R1: With an effective exponent x from 1 to 8, the k-th master rising edge after activation (k = 0 for the edge that first samples the block active) leaves `clk_o` equal to bit x-1 of (k mod 256). This gives a period of 2^x master cycles, a first phase that is low, and equal high and low phases.
- R2: With an effective exponent of 0 and the block active, `clk_o` is high while `clk_i` is high and low while `clk_i` is low.
- R3: Exponent input values 9 to 15 produce exactly the same output as the value 8.
- R4: After an edge that samples the block inactive with `lowmode_i` = 0, `oe_o` is 0 and `clk_o` is 0. The pad is then released to high impedance.
- R5: After an edge that samples the block inactive with `lowmode_i` = 1, `oe_o` is 1 and `clk_o` is 0. The pad is then driven low.
- R6: After an edge that samples the block active, `oe_o` is 1.
- R7: A change of `exp_i` while the block is active takes effect only at the edge where the counter holds 255, counting from activation. Up to and including that edge (k = 255) the old ratio applies, and from k = 256 onward the new ratio applies, starting from a low phase.
- R8: A single inactive edge restarts the counter, and the next active edge is again k = 0 of R1.
- R9: While `rst_i` is high (synchronous, active high), each edge clears the counter, drives `clk_o` low, loads `oe_o` from `lowmode_i` and samples `exp_i`. The first edge with `rst_i` low and the block active is k = 0.
- R10: The block is active exactly when `en_i` = 1 and `pd_i` = 0. A high `pd_i` makes the block inactive regardless of `en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| exp_i | input | 4 | Division exponent; values above 8 act as 8 |
| en_i | input | 1 | Output enable, active high |
| pd_i | input | 1 | Power-down, active high |
| lowmode_i | input | 1 | Inactive pad state: 1 = driven low, 0 = high impedance |
| clk_o | output | 1 | Divided clock (data to the pad) |
| oe_o | output | 1 | Pad driver enable |

## Verification
The assertions check the following on every cycle:
- the held exponent never exceeds 8;
- the held exponent only changes on an inactive cycle, a reset, or a counter wrap;
- the counter is at zero after any inactive edge;
- the driver enable and the low data level match the activity and mode sampled one edge earlier.

Only the bench's scenarios can show the following:
- the actual waveform for each ratio, including its phase relative to activation;
- the pass-through behaviour at exponent zero in both clock phases;
- that out-of-range exponents give the same waveform as 8;
- the exact edge at which a mid-run ratio change lands.

// File: rtl/pow2_prescaler_pkg.sv
package pow2_prescaler_pkg;
  localparam int unsigned DEF_EXP_W   = 4;
  localparam int unsigned DEF_EXP_MAX = 8;

  function automatic int unsigned sel_width(input int unsigned max_exp);
    return (max_exp < 2) ? 1 : $clog2(max_exp + 1);
  endfunction
endpackage

// File: rtl/pow2_ctr.sv
module pow2_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;
endmodule

// File: rtl/pow2_expsel.sv
module pow2_expsel #(
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned EXP_MAX = 8,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned SEL_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [SEL_W-1:0] exp_o,
  output logic             tap_o,
  output logic             zero_o
);
  logic [SEL_W-1:0] exp_clamp;
  logic [SEL_W-1:0] exp_q;
  logic [EXP_MAX:0] taps;

  always_comb begin
    if (int'(exp_i) > int'(EXP_MAX)) exp_clamp = SEL_W'(EXP_MAX);
    else                             exp_clamp = SEL_W'(exp_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i || wrap_i) exp_q <= exp_clamp;
  end

  assign taps[0] = 1'b0;
  for (genvar i = 1; i <= int'(EXP_MAX); i++) begin : g_tap
    assign taps[i] = cnt_i[i-1];
  end

  always_comb begin
    tap_o = 1'b0;
    for (int i = 0; i <= int'(EXP_MAX); i++) begin
      if (exp_q == SEL_W'(i)) tap_o = taps[i];
    end
  end

  assign exp_o  = exp_q;
  assign zero_o = (exp_q == '0);
endmodule

// File: rtl/pow2_drive.sv
module pow2_drive (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic lowmode_i,
  input  logic tap_i,
  input  logic zero_i,
  output logic clk_o,
  output logic oe_o
);
  logic div_q;
  logic pass_q;
  logic oe_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q  <= 1'b0;
      pass_q <= 1'b0;
      oe_q   <= lowmode_i;
    end else begin
      div_q  <= run_i & tap_i;
      pass_q <= run_i & zero_i;
      oe_q   <= run_i | lowmode_i;
    end
  end

  assign clk_o = pass_q ? clk_i : div_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/pow2_prescaler.sv
module pow2_prescaler
  import pow2_prescaler_pkg::*;
#(
  parameter int unsigned EXP_W   = DEF_EXP_W,
  parameter int unsigned EXP_MAX = DEF_EXP_MAX
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             en_i,
  input  logic             pd_i,
  input  logic             lowmode_i,
  output logic             clk_o,
  output logic             oe_o
);
  localparam int unsigned CNT_W = EXP_MAX;
  localparam int unsigned SEL_W = sel_width(EXP_MAX);

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [SEL_W-1:0] exp_sel;
  logic             tap;
  logic             zero;

  assign run = en_i & ~pd_i;

  pow2_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .run_i (run),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  pow2_expsel #(
    .EXP_W  (EXP_W),
    .EXP_MAX(EXP_MAX),
    .CNT_W  (CNT_W),
    .SEL_W  (SEL_W)
  ) u_sel (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .run_i (run),
    .wrap_i(wrap),
    .exp_i (exp_i),
    .cnt_i (cnt),
    .exp_o (exp_sel),
    .tap_o (tap),
    .zero_o(zero)
  );

  pow2_drive u_drv (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .run_i    (run),
    .lowmode_i(lowmode_i),
    .tap_i    (tap),
    .zero_i   (zero),
    .clk_o    (clk_o),
    .oe_o     (oe_o)
  );
endmodule

// File: rtl/pow2_prescaler_chk.sv
module pow2_prescaler_chk #(
  parameter int unsigned EXP_MAX = 8,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned SEL_W   = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic             pd_i,
  input logic             lowmode_i,
  input logic             clk_o,
  input logic             oe_o,
  input logic             run,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] exp_sel
);
  assert_exp_clamped_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(exp_sel) <= int'(EXP_MAX));

  assert_exp_changes_at_wrap_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$stable(exp_sel)) |-> $past(!run || wrap));

  assert_restart_from_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(!(en_i && !pd_i))) |-> (cnt == '0));

  assert_driver_on_when_active_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(en_i && !pd_i)) |-> oe_o);

  assert_inactive_pad_state_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(!en_i || pd_i)) |-> (!clk_o && (oe_o == $past(lowmode_i))));
endmodule

bind pow2_prescaler pow2_prescaler_chk #(
  .EXP_MAX(EXP_MAX),
  .CNT_W  (CNT_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .en_i     (en_i),
  .pd_i     (pd_i),
  .lowmode_i(lowmode_i),
  .clk_o    (clk_o),
  .oe_o     (oe_o),
  .run      (run),
  .wrap     (wrap),
  .cnt      (cnt),
  .exp_sel  (exp_sel)
);

// File: tb/pow2_prescaler_test.sv
module pow2_prescaler_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] exp_in;
  logic       en;
  logic       pd;
  logic       lowmode;
  logic       clk_out;
  logic       oe;
  int         tests = 0;
  int         fails = 0;

  always #5 clk = ~clk;

  pow2_prescaler uut (
    .clk_i    (clk),
    .rst_i    (rst),
    .exp_i    (exp_in),
    .en_i     (en),
    .pd_i     (pd),
    .lowmode_i(lowmode),
    .clk_o    (clk_out),
    .oe_o     (oe)
  );

  task automatic chk(input string req, input logic act, input logic expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, expv);
    end
  endtask

  function automatic logic model_bit(input int x, input int k);
    return logic'(((k % 256) >> (x - 1)) & 1);
  endfunction

  task automatic go_inactive(input logic use_pd, input logic [3:0] x);
    @(negedge clk);
    exp_in = x;
    if (use_pd) begin pd = 1'b1; en = 1'b1; end
    else        begin pd = 1'b0; en = 1'b0; end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic go_active();
    en = 1'b1;
    pd = 1'b0;
  endtask

  // Samples edges k = 0..n-1 after activation; caller is at a negedge.
  task automatic run_seq(input int x, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      if (x == 0) begin
        chk({req, " pass high"}, clk_out, 1'b1);
        chk("R6 oe active", oe, 1'b1);
        @(negedge clk); #1;
        chk({req, " pass low"}, clk_out, 1'b0);
      end else begin
        chk(req, clk_out, model_bit(x, k));
        chk("R6 oe active", oe, 1'b1);
      end
    end
  endtask

  task automatic check_inactive(input logic mode, input logic use_pd, input string req);
    lowmode = mode;
    go_inactive(use_pd, 4'd3);
    @(posedge clk); #2;
    chk({req, " clk_o"}, clk_out, 1'b0);
    chk({req, " oe_o"}, oe, mode);
    @(negedge clk); #1;
    chk({req, " clk_o low phase"}, clk_out, 1'b0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; exp_in = 4'd2; en = 1'b1; pd = 1'b0; lowmode = 1'b1;

    // R9: reset state in both pad modes
    @(negedge clk); @(negedge clk);
    chk("R9 reset clk_o", clk_out, 1'b0);
    chk("R9 reset oe low-mode", oe, 1'b1);
    lowmode = 1'b0;
    @(negedge clk);
    chk("R9 reset oe hiz-mode", oe, 1'b0);
    chk("R9 reset clk_o hiz-mode", clk_out, 1'b0);
    rst = 1'b0;
    run_seq(2, 10, "R9 first edge after reset");

    // R1, R2, R3: sweep of every exponent code
    for (int x = 0; x < 16; x++) begin
      int xc;
      string tag;
      xc = (x > 8) ? 8 : x;
      tag = (x == 0) ? "R2 passthrough" : ((x > 8) ? "R3 saturated" : "R1 ratio");
      go_inactive(1'b0, 4'(x));
      go_active();
      run_seq(xc, (xc == 0) ? 4 : (2 * (1 << xc) + 2), tag);
    end

    // R4, R5, R10: inactive pad state, via enable and via power-down
    check_inactive(1'b0, 1'b0, "R4 disabled hiz");
    check_inactive(1'b1, 1'b0, "R5 disabled low");
    check_inactive(1'b0, 1'b1, "R4 R10 powerdown hiz");
    check_inactive(1'b1, 1'b1, "R5 R10 powerdown low");
    lowmode = 1'b1;
    go_inactive(1'b0, 4'd4);
    pd = 1'b1;
    @(posedge clk); #2;
    chk("R10 pd with en low clk_o", clk_out, 1'b0);
    chk("R10 pd with en low oe", oe, 1'b1);

    // R7: ratio change mid-run lands at the counter wrap
    lowmode = 1'b0;
    go_inactive(1'b0, 4'd2);
    go_active();
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #2;
      chk("R7 change at wrap", clk_out, model_bit((k <= 255) ? 2 : 5, k));
      if (k == 10) begin
        @(negedge clk);
        exp_in = 4'd5;
      end
    end

    // R8: one inactive edge restarts the phase (via en and via pd)
    go_inactive(1'b0, 4'd3);
    go_active();
    run_seq(3, 5, "R8 before restart");
    @(negedge clk); en = 1'b0;
    @(posedge clk); #2;
    chk("R8 inactive edge output", clk_out, 1'b0);
    @(negedge clk); en = 1'b1;
    run_seq(3, 16, "R8 restart via en");
    @(negedge clk); pd = 1'b1;
    @(negedge clk); pd = 1'b0;
    run_seq(3, 16, "R8 R10 restart via pd");

    // R9: reset in the middle of a run
    @(negedge clk); rst = 1'b1; lowmode = 1'b1;
    @(posedge clk); #2;
    chk("R9 mid-run reset clk_o", clk_out, 1'b0);
    chk("R9 mid-run reset oe", oe, 1'b1);
    @(negedge clk); rst = 1'b0;
    run_seq(3, 16, "R9 restart after reset");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule